// File: doc/BRIEF.md
# Action-Qualified Up-Count PWM Generator

The block produces one pulse-width-modulated output from an up-counting timebase. A counter climbs from zero to a programmable period value and then wraps to zero. Two timebase events are detected every cycle: a compare event when the counter equals the active compare value, and a period event when the counter equals the period value. Each event has its own 2-bit action code that sets, clears or toggles the output, or leaves it alone. This lets software place rising and falling edges anywhere in the cycle.

Software programs the block through a single-cycle register write port. The compare value can take effect at once, or it can be staged in a shadow register that is copied to the active compare register at the next period boundary. Staging keeps a duty-cycle change aligned to a whole PWM cycle. When events coincide they are resolved by a fixed priority. A software-force input overrides everything. The period event wins over the compare event, so a 100% duty cycle with no glitch is obtained by giving the period event the same "high" action as the compare event.

Register addresses on `wrAddr`: 0 is the period value, 1 is the compare value, and 2 is the control word. The control word fields are: bit 0 selects immediate compare loading (1) or shadow loading (0), bits [2:1] hold the compare-event action, and bits [4:3] hold the period-event action.

Top module: `pwm_aq_gen`

## Requirements
- R1: The counter counts up by one each clock from 0 to the period value (written at address 0, effective the next clock) and then wraps to 0. A counter that is already above a newly written period also wraps to 0. The output period is therefore period+1 clocks.
- R2: When the counter equals the active compare value and no higher-priority event occurs, the compare action (control bits [2:1]) is applied to `pwmOut` on the following clock edge.
- R3: When the counter equals the period value and no force is present, the period action (control bits [4:3]) is applied to `pwmOut` on the following clock edge.
- R4: Action code encoding: 0 holds the output, 1 drives it low, 2 drives it high, 3 toggles it. In a cycle with no event and no force, the output holds.
- R5: If the period event and the compare event occur in the same cycle, only the period action is applied.
- R6: When `forceValid` is 1, `forceAction` (same encoding as R4, so code 0 holds) is applied on the next edge and overrides any timebase event in that cycle.
- R7: With control bit 0 = 0, a compare write goes to the shadow register and is copied to the active compare only in a cycle where the counter is at or above the period value. The active compare does not change at any other time.
- R8: With control bit 0 = 1, a compare write updates the active compare on the next clock edge, in the current PWM cycle.
- R9: A control-word write changes the event actions from the next clock edge, without waiting for a period boundary.
- R10: Reset (active-low `rstN`) clears the output, the counter, the period, the shadow compare, the active compare and the control word to 0.
- R11: With compare 0, compare action 2 and period action 2, `pwmOut` stays high on every cycle once it has been set, with no one-cycle low pulse at the period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address (0 period, 1 compare, 2 control) |
| wrData | input | CNT_W | Write data |
| forceValid | input | 1 | Apply a software-forced action this cycle |
| forceAction | input | 2 | Forced action code |
| pwmOut | output | 1 | PWM output |

## Verification
The functions that can fall in the same cycle are the period event and the compare event, with a forced action sometimes on top of both. The bench makes them coincide in two ways. It programs the compare value equal to the period value, and it programs compare 0 with both actions high, which is the 100% duty case. It also issues a long run of forced actions so that some of them land on event cycles. A cycle-accurate model built from the requirements predicts the output for every clock, and each mismatch is reported against the rule that decided that cycle: force, then period, then compare.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  localparam logic [1:0] ADDR_PERIOD = 2'd0;
  localparam logic [1:0] ADDR_CMP    = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  localparam int CTRL_IMM_BIT  = 0;
  localparam int CTRL_CMP_LSB  = 1;
  localparam int CTRL_PRD_LSB  = 3;
  localparam int CTRL_W        = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic wrapNow;
    logic drvLow;
    logic drvHigh;
    logic flip;
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_aq_ctrl.sv
module pwm_aq_ctrl
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             forceValid,
  input  logic [1:0]       forceAction,
  input  logic [CNT_W-1:0] cntVal,
  output pwmStrobe_t       strobe,
  output logic [CNT_W-1:0] periodVal,
  output logic [CNT_W-1:0] cmpActive,
  output logic             immMode,
  output act_e             cmpAct,
  output act_e             prdAct
);

  logic [CNT_W-1:0] cmpShadow;
  logic             prdHit;
  logic             cmpHit;
  logic             wrapNow;
  logic             wrPeriod;
  logic             wrCmp;
  logic             wrCtrl;
  act_e             chosen;

  assign wrPeriod = wrEn && (wrAddr == ADDR_PERIOD);
  assign wrCmp    = wrEn && (wrAddr == ADDR_CMP);
  assign wrCtrl   = wrEn && (wrAddr == ADDR_CTRL);

  assign prdHit  = (cntVal == periodVal);
  assign cmpHit  = (cntVal == cmpActive);
  assign wrapNow = (cntVal >= periodVal);

  // period and control registers, written directly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodVal <= '0;
      immMode   <= 1'b0;
      cmpAct    <= ACT_HOLD;
      prdAct    <= ACT_HOLD;
    end else begin
      if (wrPeriod) periodVal <= wrData;
      if (wrCtrl) begin
        immMode <= wrData[CTRL_IMM_BIT];
        cmpAct  <= act_e'(wrData[CTRL_CMP_LSB +: 2]);
        prdAct  <= act_e'(wrData[CTRL_PRD_LSB +: 2]);
      end
    end
  end

  // compare: shadow staging or immediate load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpShadow <= '0;
      cmpActive <= '0;
    end else if (wrCmp && immMode) begin
      cmpShadow <= wrData;
      cmpActive <= wrData;
    end else begin
      if (wrCmp)   cmpShadow <= wrData;
      if (wrapNow) cmpActive <= cmpShadow;
    end
  end

  // fixed priority: force, then period, then compare
  always_comb begin
    if (forceValid)  chosen = act_e'(forceAction);
    else if (prdHit) chosen = prdAct;
    else if (cmpHit) chosen = cmpAct;
    else             chosen = ACT_HOLD;
  end

  always_comb begin
    strobe         = '0;
    strobe.wrapNow = wrapNow;
    strobe.drvLow  = (chosen == ACT_LOW);
    strobe.drvHigh = (chosen == ACT_HIGH);
    strobe.flip    = (chosen == ACT_TOGGLE);
  end

endmodule

// File: rtl/pwm_aq_datapath.sv
module pwm_aq_datapath
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strobe,
  output logic [CNT_W-1:0] cntVal,
  output logic             pwmOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (strobe.wrapNow) begin
      cntVal <= '0;
    end else begin
      cntVal <= cntVal + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmOut <= 1'b0;
    end else if (strobe.drvLow) begin
      pwmOut <= 1'b0;
    end else if (strobe.drvHigh) begin
      pwmOut <= 1'b1;
    end else if (strobe.flip) begin
      pwmOut <= ~pwmOut;
    end
  end

endmodule

// File: rtl/pwm_aq_gen.sv
module pwm_aq_gen
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             forceValid,
  input  logic [1:0]       forceAction,
  output logic             pwmOut
);

  pwmStrobe_t       strobe;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] periodVal;
  logic [CNT_W-1:0] cmpActive;
  logic             immMode;
  act_e             cmpAct;
  act_e             prdAct;

  pwm_aq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .forceValid  (forceValid),
    .forceAction (forceAction),
    .cntVal      (cntVal),
    .strobe      (strobe),
    .periodVal   (periodVal),
    .cmpActive   (cmpActive),
    .immMode     (immMode),
    .cmpAct      (cmpAct),
    .prdAct      (prdAct)
  );

  pwm_aq_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cntVal (cntVal),
    .pwmOut (pwmOut)
  );

endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic [CNT_W-1:0] wrData,
  input logic             forceValid,
  input logic [1:0]       forceAction,
  input logic             pwmOut,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] periodVal,
  input logic [CNT_W-1:0] cmpActive,
  input logic             immMode,
  input act_e             prdAct
);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal < periodVal) |=> (cntVal == $past(cntVal) + 1'b1));

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal >= periodVal) |=> (cntVal == '0));

  // R6
  force_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (forceValid && forceAction == 2'd1) |=> !pwmOut);

  // R6
  force_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (forceValid && forceAction == 2'd2) |=> pwmOut);

  // R5
  prd_wins_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!forceValid && cntVal == periodVal && prdAct == ACT_HIGH) |=> pwmOut);

  // R5
  prd_wins_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!forceValid && cntVal == periodVal && prdAct == ACT_LOW) |=> !pwmOut);

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal < periodVal && !(wrEn && wrAddr == ADDR_CMP && immMode))
      |=> $stable(cmpActive));

  // R8
  imm_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_CMP && immMode) |=> (cmpActive == $past(wrData)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!forceValid && cntVal != periodVal && cntVal != cmpActive) |=> $stable(pwmOut));

endmodule

bind pwm_aq_gen pwm_aq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrAddr      (wrAddr),
  .wrData      (wrData),
  .forceValid  (forceValid),
  .forceAction (forceAction),
  .pwmOut      (pwmOut),
  .cntVal      (cntVal),
  .periodVal   (periodVal),
  .cmpActive   (cmpActive),
  .immMode     (immMode),
  .prdAct      (prdAct)
);

// File: tb/test_pwm_aq_gen.sv
`timescale 1ns/1ps
module test_pwm_aq_gen;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       wrAddr = 2'd0;
  logic [CNT_W-1:0] wrData = '0;
  logic             forceValid = 1'b0;
  logic [1:0]       forceAction = 2'd0;
  logic             pwmOut;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  string phaseTag = "";

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t sbQ[$];

  always #5 clk = ~clk;

  pwm_aq_gen #(.CNT_W(CNT_W)) i_pwm_aq_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .forceValid(forceValid), .forceAction(forceAction), .pwmOut(pwmOut)
  );

  // ---------------- reference model (from the requirements) ----------------
  int unsigned mCnt, mPrd, mSh, mAct;
  bit          mImm, mOut;
  bit [1:0]    mCa, mPa;

  function automatic bit applyAct(bit [1:0] code, bit cur);
    case (code)
      2'd1:    return 1'b0;
      2'd2:    return 1'b1;
      2'd3:    return ~cur;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk) begin
    item_t it;
    if (!rstN) begin
      mCnt = 0; mPrd = 0; mSh = 0; mAct = 0;
      mImm = 0; mCa = 0; mPa = 0; mOut = 0;
      it.exp = 1'b0; it.tag = "R10";
    end else begin
      bit eP, eC, wrap;
      bit [1:0] code;
      string tg;
      eP = (mCnt == mPrd);
      eC = (mCnt == mAct);
      wrap = (mCnt >= mPrd);
      if (forceValid)  begin code = forceAction; tg = "R6"; end
      else if (eP)     begin code = mPa; tg = eC ? "R5" : "R3"; end
      else if (eC)     begin code = mCa; tg = "R2"; end
      else             begin code = 2'd0; tg = "R4"; end
      if (code == 2'd3) tg = "R4";
      mOut = applyAct(code, mOut);
      mCnt = wrap ? 0 : mCnt + 1;
      if (wrEn && wrAddr == 2'd1 && mImm) begin
        mSh = wrData; mAct = wrData;
      end else begin
        if (wrap) mAct = mSh;
        if (wrEn && wrAddr == 2'd1) mSh = wrData;
      end
      if (wrEn && wrAddr == 2'd0) mPrd = wrData;
      if (wrEn && wrAddr == 2'd2) begin
        mImm = wrData[0]; mCa = wrData[2:1]; mPa = wrData[4:3];
      end
      it.exp = mOut;
      it.tag = (phaseTag != "") ? phaseTag : tg;
    end
    sbQ.push_back(it);
  end

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    item_t it;
    if (sbQ.size() > 0) begin
      it = sbQ.pop_front();
      checks++;
      if (pwmOut !== it.exp) begin
        errors++;
        $display("FAIL %s: pwmOut=%0b expected %0b at %0t", it.tag, pwmOut, it.exp, $time);
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic wr(input logic [1:0] a, input int unsigned d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = CNT_W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frc(input logic [1:0] a);
    @(negedge clk);
    forceValid = 1'b1; forceAction = a;
    @(negedge clk);
    forceValid = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // R1: spacing of rising edges equals period+1
  task automatic measurePeriod(input int expected);
    int gap = 0;
    bit prev;
    bit seen = 1'b0;
    bit got = 1'b0;
    @(negedge clk);
    prev = pwmOut;
    for (int i = 0; i < 400 && !got; i++) begin
      @(negedge clk);
      if (seen) gap++;
      if (pwmOut && !prev) begin
        if (seen) got = 1'b1;
        seen = 1'b1;
      end
      prev = pwmOut;
    end
    checks++;
    if (!got || gap != expected) begin
      errors++;
      $display("FAIL R1: output period=%0d expected %0d", gap, expected);
    end
  endtask

  // R11: no low sample over a window
  task automatic checkSolidHigh(input int n);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!pwmOut) lows++;
    end
    checks++;
    if (lows != 0) begin
      errors++;
      $display("FAIL R11: low cycles=%0d expected 0", lows);
    end
  endtask

  // control word: bit0 immediate, [2:1] compare action, [4:3] period action
  function automatic int unsigned ctl(int unsigned pa, int unsigned ca, int unsigned im);
    return (pa << 3) | (ca << 1) | im;
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    idle(3);
    rstN = 1'b1;
    // R2 / R3: compare sets high, period sets low
    wr(2'd2, ctl(1, 2, 1));
    wr(2'd1, 5);
    wr(2'd0, 19);
    idle(40);
    measurePeriod(20);
    // R7: shadow loading
    phaseTag = "R7";
    wr(2'd2, ctl(1, 2, 0));
    wr(2'd1, 12);
    idle(50);
    // R8: immediate loading
    phaseTag = "R8";
    wr(2'd2, ctl(1, 2, 1));
    wr(2'd1, 3);
    idle(30);
    wr(2'd1, 15);
    idle(30);
    // R5: coincident events
    phaseTag = "";
    wr(2'd1, 19);
    idle(45);
    // R4: toggle actions
    wr(2'd2, ctl(3, 3, 1));
    wr(2'd1, 7);
    idle(45);
    // R9: action change immediate
    phaseTag = "R9";
    wr(2'd2, ctl(2, 1, 1));
    idle(40);
    // R6: forced actions landing on all phases
    phaseTag = "";
    wr(2'd2, ctl(1, 2, 1));
    wr(2'd1, 5);
    idle(10);
    for (int k = 0; k < 30; k++) begin
      frc(2'(k % 4));
      idle(k % 3);
    end
    idle(20);
    // R11: 100% duty without glitch
    phaseTag = "R11";
    wr(2'd2, ctl(2, 2, 1));
    wr(2'd1, 0);
    idle(25);
    checkSolidHigh(80);
    phaseTag = "";
    // R1: shrink period below current count
    wr(2'd2, ctl(1, 2, 1));
    wr(2'd1, 2);
    wr(2'd0, 4);
    idle(20);
    measurePeriod(5);
    idle(5);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

endmodule